// File: doc/BRIEF.md
# Vectored Two-Path Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and steers each one to one of two request outputs: a normal request and a fast request. Each line has an enable bit, a path-select bit and a 4-bit priority. A line requests when its input is high or when software has set its force bit. Pending normal lines pass through a priority arbiter. The arbiter's winner is published as a source number in a vector status word, which a handler reads in a loop until it sees the all-ones "nothing pending" code.

Software reaches the block through a simple 32-bit register bus. Writes are registered and take effect at the next clock edge. Reads are combinational. Register pairs that cover 64 sources keep sources 32..63 at the lower address and sources 0..31 at the address four bytes above it. The vector words and both request outputs follow the current pending state without a register stage. A handler that masks its source therefore reads the next winner on its very next access.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable, path-select, force and priority registers and the control word (0x00) read 0, the priority threshold (0x04) reads 0x1F, both request outputs are low and both vector words read 0xFFFF0000.
- R2: A source's request is its input OR its force bit. Enables are written whole at 0x10 (sources 63..32) and 0x14 (31..0), where 1 = unmasked. Raw inputs read at 0x48/0x4C. Normal pending (request AND enable AND path bit 0) reads at 0x58/0x5C.
- R3: Path-select bits at 0x18 (63..32) and 0x1C (31..0): 1 routes a source to the fast path, 0 to the normal path. Fast pending (request AND enable AND path bit 1) reads at 0x60/0x64. The fast output is high exactly when fast pending is nonzero.
- R4: Writing a value v below 64 to 0x08 sets enable bit v, and writing it to 0x0C clears enable bit v. A value of 64 or more written to either offset leaves all enables unchanged.
- R5: Priority word n (n = 0..7) is at 0x20 + 4*(7-n) and covers sources 8n..8n+7. Source 8n+k uses bits 4k+3:4k. The words read back as written.
- R6: The normal vector word (0x40) carries the winning source in bits 31:16, with bits 15:0 zero. The winner is the competing normal-pending source with the largest priority, and ties go to the higher source number. The word reads 0xFFFF0000 when no source competes.
- R7: A normal-pending source competes only if its priority is strictly greater than the threshold at 0x04 (5 bits). A threshold of 0x1F disables this filter. The normal output is high exactly when some source competes.
- R8: The fast vector word (0x44) carries in bits 31:16 the highest-numbered fast-pending source, or 0xFFFF when there is none. Bits 15:0 are zero.
- R9: The force registers at 0x50 (63..32) and 0x54 (31..0) and the control word at 0x00 read back as written.
- R10: Both request outputs and all status words follow a change on the interrupt inputs with no clock delay. They reflect a register write from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl | input | 64 | Level-sensitive interrupt inputs |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| nirq_o | output | 1 | Normal interrupt request |
| firq_o | output | 1 | Fast interrupt request |

## Verification
Register writes land at the rising edge where the strobe is sampled. The bench therefore updates its reference model just after that edge and reads back from the following falling edge. Status words and request outputs are combinational in the inputs. Their checks change an input and sample a nanosecond later with no clock edge in between. A reference model computes the expected request outputs every cycle, and the bench compares them a few nanoseconds after each falling edge. Scripted reads then cover tie-breaking, the threshold, the reversed layout of the priority words and ignored out-of-range numbers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam logic [7:0] A_CTRL   = 8'h00;
   localparam logic [7:0] A_THRESH = 8'h04;
   localparam logic [7:0] A_ENNUM  = 8'h08;
   localparam logic [7:0] A_DISNUM = 8'h0C;
   localparam logic [7:0] A_ENH    = 8'h10;
   localparam logic [7:0] A_ENL    = 8'h14;
   localparam logic [7:0] A_PATHH  = 8'h18;
   localparam logic [7:0] A_PATHL  = 8'h1C;
   localparam logic [7:0] A_PRIO   = 8'h20;
   localparam logic [7:0] A_NVEC   = 8'h40;
   localparam logic [7:0] A_FVEC   = 8'h44;
   localparam logic [7:0] A_RAWH   = 8'h48;
   localparam logic [7:0] A_RAWL   = 8'h4C;
   localparam logic [7:0] A_FRCH   = 8'h50;
   localparam logic [7:0] A_FRCL   = 8'h54;
   localparam logic [7:0] A_NPH    = 8'h58;
   localparam logic [7:0] A_NPL    = 8'h5C;
   localparam logic [7:0] A_FPH    = 8'h60;
   localparam logic [7:0] A_FPL    = 8'h64;
   localparam logic [4:0]  THRESH_OFF = 5'h1F;
   localparam logic [15:0] NO_VECTOR  = 16'hFFFF;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   localparam int IW     = $clog2(NUM_SRC),
   localparam int HALF   = NUM_SRC / 2,
   localparam int PWORDS = NUM_SRC * PRIO_W / 32,
   localparam int PIW    = $clog2(PWORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [7:0]                addr,
   input  logic [31:0]               wdata,
   output logic [NUM_SRC-1:0]        en,
   output logic [NUM_SRC-1:0]        path,
   output logic [NUM_SRC-1:0]        frc,
   output logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic [4:0]                thresh,
   output logic [31:0]               ctrl
);
   logic           p_hit;
   logic [PIW-1:0] p_idx;
   logic           num_ok;

   always_comb begin
      p_hit  = (addr >= A_PRIO) && (addr < 8'(A_PRIO + 4 * PWORDS));
      p_idx  = PIW'(PWORDS - 1) - PIW'((addr - A_PRIO) >> 2);
      num_ok = (wdata < 32'(NUM_SRC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         path   <= '0;
         frc    <= '0;
         prio   <= '0;
         thresh <= THRESH_OFF;
         ctrl   <= '0;
      end else if (we) begin
         if (p_hit) prio[32*p_idx +: 32] <= wdata;
         case (addr)
            A_CTRL:   ctrl   <= wdata;
            A_THRESH: thresh <= wdata[4:0];
            A_ENNUM:  if (num_ok) en[wdata[IW-1:0]] <= 1'b1;
            A_DISNUM: if (num_ok) en[wdata[IW-1:0]] <= 1'b0;
            A_ENH:    en[NUM_SRC-1:HALF]   <= wdata;
            A_ENL:    en[HALF-1:0]         <= wdata;
            A_PATHH:  path[NUM_SRC-1:HALF] <= wdata;
            A_PATHL:  path[HALF-1:0]       <= wdata;
            A_FRCH:   frc[NUM_SRC-1:HALF]  <= wdata;
            A_FRCL:   frc[HALF-1:0]        <= wdata;
            default: ;
         endcase
      end
   end

   p_ennum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_ENNUM && wdata < 32'(NUM_SRC)) |=> en[$past(wdata[IW-1:0])]);
   p_disnum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_DISNUM && wdata < 32'(NUM_SRC)) |=> !en[$past(wdata[IW-1:0])]);
   p_numign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == A_ENNUM || addr == A_DISNUM) && wdata >= 32'(NUM_SRC)) |=> $stable(en));
   p_thresh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we || addr != A_THRESH) |=> $stable(thresh));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   localparam int IW     = $clog2(NUM_SRC),
   localparam int LV     = IW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        elig,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic                      win_vld,
   output logic [IW-1:0]             win_idx
);
   if ((1 << IW) != NUM_SRC) begin : g_bad_n
      $error("irqc_arb: NUM_SRC must be a power of two");
   end

   for (genvar L = 0; L <= LV; L++) begin : g_lv
      localparam int W = NUM_SRC >> L;
      logic [W-1:0]  v;
      logic [PRIO_W-1:0] p [W];
      logic [IW-1:0] id [W];
      if (L == 0) begin : g_leaf
         for (genvar j = 0; j < W; j++) begin : g_j
            assign v[j]  = elig[j];
            assign p[j]  = prio[j*PRIO_W +: PRIO_W];
            assign id[j] = IW'(j);
         end
      end else begin : g_node
         for (genvar j = 0; j < W; j++) begin : g_j
            logic take_hi;
            assign take_hi = g_lv[L-1].v[2*j+1] &&
                             (!g_lv[L-1].v[2*j] || g_lv[L-1].p[2*j+1] >= g_lv[L-1].p[2*j]);
            assign v[j]  = g_lv[L-1].v[2*j] | g_lv[L-1].v[2*j+1];
            assign p[j]  = take_hi ? g_lv[L-1].p[2*j+1]  : g_lv[L-1].p[2*j];
            assign id[j] = take_hi ? g_lv[L-1].id[2*j+1] : g_lv[L-1].id[2*j];
         end
      end
   end

   assign win_vld = g_lv[LV].v[0];
   assign win_idx = g_lv[LV].id[0];

   logic beaten;
   always_comb begin
      beaten = 1'b0;
      for (int j = 0; j < NUM_SRC; j++) begin
         if (elig[j] && (prio[j*PRIO_W +: PRIO_W] > prio[win_idx*PRIO_W +: PRIO_W] ||
             (prio[j*PRIO_W +: PRIO_W] == prio[win_idx*PRIO_W +: PRIO_W] && j > int'(win_idx))))
            beaten = 1'b1;
      end
   end

   p_best_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (elig[win_idx] && !beaten));
   p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_vld |-> (elig == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lvl,
   input  logic               bus_we,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               nirq_o,
   output logic               firq_o
);
   localparam int IW     = $clog2(NUM_SRC);
   localparam int HALF   = NUM_SRC / 2;
   localparam int PWORDS = NUM_SRC * PRIO_W / 32;

   if (NUM_SRC != 64) begin : g_bad_n
      $error("irqc_top: register map is laid out for 64 sources");
   end
   if (NUM_SRC * PRIO_W != 256 || (32 % PRIO_W) != 0) begin : g_bad_pw
      $error("irqc_top: priority fields must fill eight 32-bit words");
   end

   logic [NUM_SRC-1:0]        en, path, frc, req, npend, fpend, compete;
   logic [NUM_SRC*PRIO_W-1:0] prio;
   logic [4:0]                thresh;
   logic [31:0]               ctrl;
   logic                      n_vld, f_vld;
   logic [IW-1:0]             n_idx, f_idx;
   logic [15:0]               nvec, fvec;

   irqc_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .en(en), .path(path), .frc(frc), .prio(prio), .thresh(thresh), .ctrl(ctrl));

   assign req   = irq_lvl | frc;
   assign npend = req & en & ~path;
   assign fpend = req & en & path;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
      assign compete[i] = npend[i] &&
         (thresh == THRESH_OFF || {1'b0, prio[i*PRIO_W +: PRIO_W]} > {{(5-PRIO_W){1'b0}}, thresh} >> 0);
   end

   irqc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_narb (
      .clk(clk), .rst_n(rst_n), .elig(compete), .prio(prio),
      .win_vld(n_vld), .win_idx(n_idx));

   irqc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_farb (
      .clk(clk), .rst_n(rst_n), .elig(fpend), .prio('0),
      .win_vld(f_vld), .win_idx(f_idx));

   assign nvec   = n_vld ? 16'(n_idx) : NO_VECTOR;
   assign fvec   = f_vld ? 16'(f_idx) : NO_VECTOR;
   assign nirq_o = n_vld;
   assign firq_o = f_vld;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr >= A_PRIO && bus_addr < 8'(A_PRIO + 4 * PWORDS)) begin
         bus_rdata = prio[32*(PWORDS - 1 - int'((bus_addr - A_PRIO) >> 2)) +: 32];
      end else begin
         case (bus_addr)
            A_CTRL:   bus_rdata = ctrl;
            A_THRESH: bus_rdata = {27'd0, thresh};
            A_ENH:    bus_rdata = en[NUM_SRC-1:HALF];
            A_ENL:    bus_rdata = en[HALF-1:0];
            A_PATHH:  bus_rdata = path[NUM_SRC-1:HALF];
            A_PATHL:  bus_rdata = path[HALF-1:0];
            A_NVEC:   bus_rdata = {nvec, 16'd0};
            A_FVEC:   bus_rdata = {fvec, 16'd0};
            A_RAWH:   bus_rdata = irq_lvl[NUM_SRC-1:HALF];
            A_RAWL:   bus_rdata = irq_lvl[HALF-1:0];
            A_FRCH:   bus_rdata = frc[NUM_SRC-1:HALF];
            A_FRCL:   bus_rdata = frc[HALF-1:0];
            A_NPH:    bus_rdata = npend[NUM_SRC-1:HALF];
            A_NPL:    bus_rdata = npend[HALF-1:0];
            A_FPH:    bus_rdata = fpend[NUM_SRC-1:HALF];
            A_FPL:    bus_rdata = fpend[HALF-1:0];
            default:  bus_rdata = '0;
         endcase
      end
   end

   p_nirq_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nirq_o |-> (npend != '0));
   p_fvec_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      firq_o |-> fpend[f_idx]);
   p_firq_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
      firq_o |-> ((path & en) != '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lvl = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        nirq_o, firq_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bit [63:0] m_en, m_ty, m_fr;
   int        m_pr[64];
   int        m_th;
   bit [31:0] m_ctrl;

   irqc_top dut (.clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .nirq_o(nirq_o), .firq_o(firq_o));

   always #5 clk = ~clk;

   function automatic bit m_req(int i);
      return irq_lvl[i] | m_fr[i];
   endfunction

   function automatic int m_nwin();
      int b = -1;
      int bp = 0;
      for (int i = 0; i < 64; i++)
         if (m_req(i) && m_en[i] && !m_ty[i] && (m_th == 31 || m_pr[i] > m_th))
            if (b < 0 || m_pr[i] >= bp) begin b = i; bp = m_pr[i]; end
      return b;
   endfunction

   function automatic int m_fwin();
      int b = -1;
      for (int i = 0; i < 64; i++)
         if (m_req(i) && m_en[i] && m_ty[i]) b = i;
      return b;
   endfunction

   function automatic bit [31:0] vec_word(int w);
      return (w < 0) ? 32'hFFFF_0000 : (32'(w) << 16);
   endfunction

   task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_we = 1'b0;
      case (a)
         8'h00: m_ctrl = d;
         8'h04: m_th = int'(d[4:0]);
         8'h08: if (d < 64) m_en[d] = 1'b1;
         8'h0C: if (d < 64) m_en[d] = 1'b0;
         8'h10: m_en[63:32] = d;
         8'h14: m_en[31:0]  = d;
         8'h18: m_ty[63:32] = d;
         8'h1C: m_ty[31:0]  = d;
         8'h50: m_fr[63:32] = d;
         8'h54: m_fr[31:0]  = d;
         default: if (a >= 8'h20 && a <= 8'h3C) begin
            int n = 7 - int'((a - 8'h20) / 4);
            for (int f = 0; f < 8; f++) m_pr[8*n+f] = int'((d >> (4*f)) & 32'hF);
         end
      endcase
   endtask

   task automatic rd_chk(string tag, bit [7:0] a, bit [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 check(tag, bus_rdata, exp);
   endtask

   // every-cycle comparison of both request outputs with the reference model
   always @(negedge clk) begin
      #3;
      if (rst_n && !done) begin
         check("R7 nirq per-cycle", 32'(nirq_o), 32'(m_nwin() >= 0));
         check("R3 firq per-cycle", 32'(firq_o), 32'(m_fwin() >= 0));
      end
   end

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_en = '0; m_ty = '0; m_fr = '0; m_th = 31; m_ctrl = '0;
      for (int i = 0; i < 64; i++) m_pr[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 threshold", 8'h04, 32'h1F);
      rd_chk("R1 enable low", 8'h14, 0);
      rd_chk("R1 path high", 8'h18, 0);
      rd_chk("R1 prio word", 8'h2C, 0);
      rd_chk("R1 control", 8'h00, 0);
      rd_chk("R1 nvec", 8'h40, 32'hFFFF_0000);
      rd_chk("R1 fvec", 8'h44, 32'hFFFF_0000);
      check("R1 outputs", {30'd0, nirq_o, firq_o}, 0);

      // R9 control readback
      wr(8'h00, 32'hA5C3_0F01);
      rd_chk("R9 control", 8'h00, 32'hA5C3_0F01);

      // R2 masked source is raw but not pending
      irq_lvl[5] = 1'b1;
      rd_chk("R2 raw low", 8'h4C, 32'h20);
      rd_chk("R2 pend masked", 8'h5C, 0);
      rd_chk("R6 none", 8'h40, 32'hFFFF_0000);
      wr(8'h14, 32'h20);
      rd_chk("R2 pend low", 8'h5C, 32'h20);
      rd_chk("R6 single", 8'h40, 32'h0005_0000);

      // R4 enable by number, R6 tie to higher number
      wr(8'h08, 40);
      irq_lvl[40] = 1'b1;
      rd_chk("R4 en high", 8'h10, 32'h100);
      rd_chk("R6 tie", 8'h40, 32'h0028_0000);

      // R5 reversed priority words
      wr(8'h3C, 32'h0030_0000);
      rd_chk("R5 word0 readback", 8'h3C, 32'h0030_0000);
      rd_chk("R6 prio 5 wins", 8'h40, 32'h0005_0000);
      wr(8'h28, 32'h0000_0003);
      rd_chk("R6 equal prio tie", 8'h40, 32'h0028_0000);
      wr(8'h28, 32'h0000_0007);
      rd_chk("R5 word5 readback", 8'h28, 32'h7);
      rd_chk("R6 higher wins", 8'h40, vec_word(m_nwin()));

      // R7 threshold
      wr(8'h04, 5);
      rd_chk("R7 thr 5", 8'h40, 32'h0028_0000);
      wr(8'h04, 7);
      rd_chk("R7 all below", 8'h40, 32'hFFFF_0000);
      check("R7 nirq low", 32'(nirq_o), 0);
      wr(8'h04, 32'h1F);
      rd_chk("R7 thr off", 8'h40, 32'h0028_0000);

      // R4 disable and ignored numbers
      wr(8'h0C, 40);
      rd_chk("R4 dis next winner", 8'h40, 32'h0005_0000);
      rd_chk("R4 en high cleared", 8'h10, 0);
      wr(8'h08, 64);
      rd_chk("R4 en ign 64 high", 8'h10, 0);
      rd_chk("R4 en ign 64 low", 8'h14, 32'h20);
      wr(8'h0C, 100);
      rd_chk("R4 dis ign 100", 8'h14, 32'h20);
      rd_chk("R4 vec unchanged", 8'h40, 32'h0005_0000);

      // R3 / R8 fast path
      wr(8'h1C, 32'h20);
      rd_chk("R3 fast pend", 8'h64, 32'h20);
      rd_chk("R3 normal pend gone", 8'h5C, 0);
      rd_chk("R8 fvec", 8'h44, 32'h0005_0000);
      check("R3 firq", {30'd0, nirq_o, firq_o}, 32'b01);

      // R9 force drives request, R8 highest fast number
      wr(8'h08, 50);
      wr(8'h18, 32'h0004_0000);
      wr(8'h50, 32'h0004_0000);
      rd_chk("R9 force readback", 8'h50, 32'h0004_0000);
      rd_chk("R8 fvec highest", 8'h44, 32'h0032_0000);
      rd_chk("R3 fast pend high", 8'h60, 32'h0004_0000);
      wr(8'h54, 32'h8000_0001);
      rd_chk("R9 force low", 8'h54, 32'h8000_0001);
      rd_chk("R2 raw unaffected", 8'h4C, 32'h20);

      // R10 combinational response to inputs
      wr(8'h1C, 0);
      wr(8'h50, 0);
      @(negedge clk);
      bus_addr = 8'h40;
      #1 check("R10 before", bus_rdata, 32'h0005_0000);
      irq_lvl[5] = 1'b0;
      #1 check("R10 vec follows input", bus_rdata, vec_word(m_nwin()));
      check("R10 nirq follows input", 32'(nirq_o), 32'(m_nwin() >= 0));
      wr(8'h14, 32'hFFFF_FFFF);
      rd_chk("R10 after enable write", 8'h40, vec_word(m_nwin()));

      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule